// File: doc/BRIEF.md
# UDP Frame Byte-Stream Generator

This block turns a fixed-length payload into a complete broadcast Ethernet frame that carries IPv4 and UDP, as a byte stream for a transmit MAC front end. A producer pushes the payload bytes over a valid/ready byte port. Once the last byte is stored, the block sends the whole frame back to back, one byte per clock, with a flag that marks the active bytes. The frame holds the preamble and start delimiter, the Ethernet header, the IPv4 header, the UDP header, the payload and a CRC-32 frame check sequence.

The addresses, ports, identification and TTL are parameters. The IPv4 header checksum therefore depends only on parameters and is folded at elaboration. The UDP checksum depends on the payload. It is accumulated while the bytes arrive, so it is complete before the header goes out. The FCS is computed on the fly as the bytes leave. After each frame the block holds a guaranteed idle gap before it accepts the next payload.

Top module: `udp_frame_gen`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: in_ready is 1 only while the payload buffer is empty and filling. It stays 0 from the cycle after the final payload byte is accepted until the gap ends, and out_valid is never 1 while in_ready is 1.
- R3: Every frame opens with seven bytes of 0x55 followed by one byte of 0xD5.
- R4: Bytes 8 to 47 of the frame (0-based) are fixed. They are destination MAC ff:ff:ff:ff:ff:ff, then source MAC 00:12:34:56:78:90, then type 0x0800. Next come the IPv4 bytes 0x45 and 0x00, total length 0x002E, identification 0xB3FE, a zero flags/fragment word, TTL 0x80, protocol 0x11, the header checksum, source address c0.a8.00.2c and destination address c0.a8.00.04. Last come the UDP source port 0x0400, destination port 0x0400 and length 0x001A. All multi-byte fields are sent most significant byte first.
- R5: Frame bytes 32 and 33 hold the ones-complement IPv4 header checksum over the 20 header bytes, computed with that field taken as zero.
- R6: Frame bytes 48 and 49 hold the UDP checksum, most significant byte first. It is the inverted ones-complement sum over four groups: the source and destination addresses, the word 0x0011, the UDP length, and the UDP header with a zero checksum, plus the payload taken as big-endian 16-bit words. A computed value of 0x0000 is sent as 0xFFFF.
- R7: Frame bytes 50 to 67 are the 18 payload bytes in the order they were accepted.
- R8: Frame bytes 68 to 71 are the FCS. It is a reflected CRC-32 with polynomial 0xEDB88320, seeded with 0xFFFFFFFF and inverted at the end. It covers bytes 8 to 67 and is sent least significant byte first.
- R9: The first preamble byte is presented in the second cycle after the cycle that accepts the final payload byte. out_valid then stays 1 for exactly 72 consecutive cycles.
- R10: in_ready returns to 1 exactly IFG_BYTES (default 12) cycles after the cycle that carries the last FCS byte, and out_valid stays 0 in between.
- R11: in_valid asserted while in_ready is 0 is ignored. The frame being sent keeps its original payload and checksums.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Block can take a payload byte |
| out_data | output | 8 | Frame byte |
| out_valid | output | 1 | out_data carries a frame byte |

## Verification
A payload byte is taken on the rising edge where in_valid and in_ready are both 1. out_valid is still 0 in the cycle after the final byte and carries the first preamble byte one cycle later. The bench therefore samples on falling edges, fixes its first frame sample to that cycle and reads 72 consecutive samples from there. After the last FCS sample it counts the idle cycles until in_ready rises and expects exactly IFG_BYTES minus one. Checksums and FCS are recomputed in the bench from the bytes it sent. That includes a payload built at run time so that the UDP sum comes to zero.

// File: rtl/udp_frame_pkg.sv
package udp_frame_pkg;

   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

   typedef enum logic [1:0] {
      ST_LOAD = 2'd0,
      ST_SEND = 2'd1,
      ST_GAP  = 2'd2
   } frame_state_e;

   // one byte through the reflected CRC-32, LSB first
   function automatic logic [31:0] crc32_step(input logic [31:0] crc, input logic [7:0] d);
      logic [31:0] c;
      c = crc ^ {24'h0, d};
      for (int b = 0; b < 8; b++) begin
         c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
      end
      return c;
   endfunction

   // end-around-carry fold of a 32-bit partial sum
   function automatic logic [15:0] ones_fold(input logic [31:0] s);
      logic [31:0] t;
      t = {16'h0, s[15:0]} + {16'h0, s[31:16]};
      t = {16'h0, t[15:0]} + {16'h0, t[31:16]};
      return t[15:0];
   endfunction

   function automatic logic [15:0] ipv4_csum(input logic [15:0] total_len,
                                             input logic [15:0] ident,
                                             input logic [7:0]  ttl,
                                             input logic [31:0] src,
                                             input logic [31:0] dst);
      logic [31:0] s;
      s = 32'h0000_4500 + {16'h0, total_len} + {16'h0, ident}
        + {16'h0, ttl, 8'h11}
        + {16'h0, src[31:16]} + {16'h0, src[15:0]}
        + {16'h0, dst[31:16]} + {16'h0, dst[15:0]};
      return ~ones_fold(s);
   endfunction

endpackage

// File: rtl/udp_payload_store.sv
module udp_payload_store
   import udp_frame_pkg::*;
#(
   parameter int unsigned LEN       = 18,
   parameter logic [31:0] SUM_SEED  = 32'h0,
   localparam int unsigned CNT_W    = $clog2(LEN + 1),
   localparam int unsigned PA_W     = $clog2(LEN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            wr_en,
   input  logic [7:0]      wr_data,
   input  logic [PA_W-1:0] rd_addr,
   output logic [7:0]      rd_data,
   output logic            last_wr,
   output logic            full,
   output logic [15:0]     udp_csum
);

   localparam int unsigned DEPTH = 1 << PA_W;

   logic [7:0]       mem [DEPTH];
   logic [CNT_W-1:0] cnt;
   logic [31:0]      sum;
   logic [15:0]      folded;

   always_ff @(posedge clk) begin
      if (wr_en) mem[PA_W'(cnt)] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt <= '0;
         sum <= SUM_SEED;
      end else if (wr_en) begin
         cnt <= cnt + 1'b1;
         // even offsets fill the high half of a 16-bit word
         sum <= cnt[0] ? (sum + {24'h0, wr_data}) : (sum + {16'h0, wr_data, 8'h00});
      end
   end

   assign full    = (cnt == CNT_W'(LEN));
   assign last_wr = wr_en && (cnt == CNT_W'(LEN - 1));
   assign rd_data = (rd_addr < PA_W'(LEN)) ? mem[rd_addr] : 8'h00;
   assign folded  = ones_fold(sum);
   assign udp_csum = (folded == 16'hFFFF) ? 16'hFFFF : ~folded;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (cnt < CNT_W'(LEN)));                                   // R11
   AST_FULL_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full) |-> $past(wr_en));                                    // R2

endmodule

// File: rtl/udp_crc32_unit.sv
module udp_crc32_unit
   import udp_frame_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init,
   input  logic        en,
   input  logic [7:0]  din,
   output logic [31:0] crc_q
);

   always_ff @(posedge clk) begin
      if (!rst_n || init) crc_q <= 32'hFFFF_FFFF;
      else if (en)        crc_q <= crc32_step(crc_q, din);
   end

   AST_CRC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!init && !en) |=> $stable(crc_q));                               // R8

endmodule

// File: rtl/udp_frame_gen.sv
module udp_frame_gen
   import udp_frame_pkg::*;
#(
   parameter int unsigned PAYLOAD_LEN  = 18,
   parameter int unsigned PREAMBLE_LEN = 7,
   parameter int unsigned IFG_BYTES    = 12,
   parameter logic [47:0] DST_MAC      = 48'hFFFF_FFFF_FFFF,
   parameter logic [47:0] SRC_MAC      = 48'h0012_3456_7890,
   parameter logic [31:0] SRC_IP       = 32'hC0A8_002C,
   parameter logic [31:0] DST_IP       = 32'hC0A8_0004,
   parameter logic [15:0] SRC_PORT     = 16'h0400,
   parameter logic [15:0] DST_PORT     = 16'h0400,
   parameter logic [15:0] IP_IDENT     = 16'hB3FE,
   parameter logic [7:0]  IP_TTL       = 8'h80
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] in_data,
   input  logic       in_valid,
   output logic       in_ready,
   output logic [7:0] out_data,
   output logic       out_valid
);

   localparam int unsigned HDR_FIX_N = PREAMBLE_LEN + 1 + 14 + 20 + 6;
   localparam int unsigned PAY_START = HDR_FIX_N + 2;
   localparam int unsigned FCS_START = PAY_START + PAYLOAD_LEN;
   localparam int unsigned FRAME_LEN = FCS_START + 4;
   localparam int unsigned CRC_START = PREAMBLE_LEN + 1;
   localparam int unsigned IDX_W     = $clog2(FRAME_LEN + 1);
   localparam int unsigned GAP_W     = $clog2(IFG_BYTES + 1);
   localparam int unsigned PA_W      = $clog2(PAYLOAD_LEN);

   localparam logic [15:0] UDP_LEN_W = 16'(8 + PAYLOAD_LEN);
   localparam logic [15:0] IP_TOT_W  = 16'(28 + PAYLOAD_LEN);
   localparam logic [15:0] IP_CSUM   = ipv4_csum(IP_TOT_W, IP_IDENT, IP_TTL, SRC_IP, DST_IP);

   localparam logic [31:0] UDP_SEED =
        {16'h0, SRC_IP[31:16]} + {16'h0, SRC_IP[15:0]}
      + {16'h0, DST_IP[31:16]} + {16'h0, DST_IP[15:0]}
      + 32'h0000_0011 + {16'h0, UDP_LEN_W}
      + {16'h0, SRC_PORT} + {16'h0, DST_PORT} + {16'h0, UDP_LEN_W};

   localparam logic [8*HDR_FIX_N-1:0] HDR_FIXED = {
      {PREAMBLE_LEN{8'h55}}, 8'hD5,
      DST_MAC, SRC_MAC, 16'h0800,
      8'h45, 8'h00, IP_TOT_W, IP_IDENT, 16'h0000, IP_TTL, 8'h11, IP_CSUM, SRC_IP, DST_IP,
      SRC_PORT, DST_PORT, UDP_LEN_W
   };

   // elaboration-time parameter checks
   if (PAYLOAD_LEN < 18) begin : g_chk_len
      $error("PAYLOAD_LEN below the minimum frame size");
   end
   if (IFG_BYTES < 12) begin : g_chk_ifg
      $error("IFG_BYTES must be at least 12");
   end
   if (PREAMBLE_LEN < 1) begin : g_chk_pre
      $error("PREAMBLE_LEN must be nonzero");
   end

   frame_state_e     state;
   logic [IDX_W-1:0] idx;
   logic [GAP_W-1:0] gcnt;
   logic [7:0]       nxt_byte;
   logic [7:0]       pay_byte;
   logic [15:0]      udp_csum;
   logic [31:0]      crc_q;
   logic [31:0]      crc_fin;
   logic [1:0]       fsel;
   logic             wr_en, last_wr, store_full, gap_done, crc_en;

   assign in_ready = (state == ST_LOAD);
   assign wr_en    = in_valid && in_ready;
   assign gap_done = (state == ST_GAP) && (gcnt == GAP_W'(IFG_BYTES - 1));
   assign crc_en   = (state == ST_SEND) && (idx >= IDX_W'(CRC_START)) && (idx < IDX_W'(FCS_START));
   assign crc_fin  = ~crc_q;
   assign fsel     = 2'(idx - IDX_W'(FCS_START));

   udp_payload_store #(
      .LEN      (PAYLOAD_LEN),
      .SUM_SEED (UDP_SEED)
   ) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (gap_done),
      .wr_en    (wr_en),
      .wr_data  (in_data),
      .rd_addr  (PA_W'(idx - IDX_W'(PAY_START))),
      .rd_data  (pay_byte),
      .last_wr  (last_wr),
      .full     (store_full),
      .udp_csum (udp_csum)
   );

   udp_crc32_unit i_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (state == ST_LOAD),
      .en    (crc_en),
      .din   (nxt_byte),
      .crc_q (crc_q)
   );

   always_comb begin
      if (idx < IDX_W'(HDR_FIX_N))
         nxt_byte = HDR_FIXED[8*(HDR_FIX_N - 1 - int'(idx)) +: 8];
      else if (idx == IDX_W'(HDR_FIX_N))
         nxt_byte = udp_csum[15:8];
      else if (idx == IDX_W'(HDR_FIX_N + 1))
         nxt_byte = udp_csum[7:0];
      else if (idx < IDX_W'(FCS_START))
         nxt_byte = pay_byte;
      else begin
         case (fsel)
            2'd0:    nxt_byte = crc_fin[7:0];
            2'd1:    nxt_byte = crc_fin[15:8];
            2'd2:    nxt_byte = crc_fin[23:16];
            default: nxt_byte = crc_fin[31:24];
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_LOAD;
         idx       <= '0;
         gcnt      <= '0;
         out_data  <= 8'h00;
         out_valid <= 1'b0;
      end else begin
         case (state)
            ST_LOAD: begin
               out_valid <= 1'b0;
               if (last_wr) begin
                  state <= ST_SEND;
                  idx   <= '0;
               end
            end
            ST_SEND: begin
               out_data  <= nxt_byte;
               out_valid <= 1'b1;
               idx       <= idx + 1'b1;
               if (idx == IDX_W'(FRAME_LEN - 1)) begin
                  state <= ST_GAP;
                  gcnt  <= '0;
               end
            end
            default: begin
               out_valid <= 1'b0;
               gcnt      <= gcnt + 1'b1;
               if (gap_done) state <= ST_LOAD;
            end
         endcase
      end
   end

   AST_READY_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !out_valid);                                         // R2
   AST_FRAME_NO_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SEND) |=> out_valid);                                // R9
   AST_GAP_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> !in_ready);                                  // R10
   AST_CRC_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (crc_q == 32'hFFFF_FFFF));                   // R8
   AST_SEND_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SEND) |-> store_full);                               // R11

endmodule

// File: tb/test_udp_frame_gen.sv
`timescale 1ns/1ps
module test_udp_frame_gen;

   localparam int PLEN  = 18;
   localparam int FLEN  = 72;
   localparam int IFG   = 12;

   localparam logic [8*PLEN-1:0] VEC [4] = '{
      144'h000102030405060708090a0b0c0d0e0f1011,
      144'h0001ffff0405060708090a0b0c0d0e0f1011,
      144'hffffffffffffffffffffffffffffffffffff,
      144'ha55aa55aa55aa55aa55aa55aa55aa55aa55a
   };

   localparam logic [7:0] HB [48] = '{
      8'h55,8'h55,8'h55,8'h55,8'h55,8'h55,8'h55,8'hd5,
      8'hff,8'hff,8'hff,8'hff,8'hff,8'hff,8'h00,8'h12,8'h34,8'h56,8'h78,8'h90,8'h08,8'h00,
      8'h45,8'h00,8'h00,8'h2e,8'hb3,8'hfe,8'h00,8'h00,8'h80,8'h11,8'h00,8'h00,
      8'hc0,8'ha8,8'h00,8'h2c,8'hc0,8'ha8,8'h00,8'h04,
      8'h04,8'h00,8'h04,8'h00,8'h00,8'h1a
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] out_data;
   logic       out_valid;

   int checks = 0;
   int failures = 0;

   logic [7:0] pay   [PLEN];
   logic [7:0] exp_f [FLEN];
   logic [7:0] got   [FLEN];

   always #2.5 clk = ~clk;

   udp_frame_gen i_udp_frame_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_data   (in_data),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .out_data  (out_data),
      .out_valid (out_valid)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   function automatic logic [15:0] fold16(input logic [31:0] s);
      logic [31:0] t;
      t = s;
      while (t[31:16] != 16'h0) t = {16'h0, t[15:0]} + {16'h0, t[31:16]};
      return t[15:0];
   endfunction

   function automatic logic [31:0] udp_partial(input int upto);
      logic [31:0] s;
      s = {16'h0, exp_f[34], exp_f[35]} + {16'h0, exp_f[36], exp_f[37]}
        + {16'h0, exp_f[38], exp_f[39]} + {16'h0, exp_f[40], exp_f[41]}
        + 32'h11 + 32'd26;
      for (int i = 42; i < 48; i += 2) s += {16'h0, exp_f[i], exp_f[i+1]};
      for (int i = 0; i < upto; i += 2) s += {16'h0, pay[i], (i + 1 < PLEN) ? pay[i+1] : 8'h00};
      return s;
   endfunction

   task automatic build_expected();
      logic [31:0] s;
      logic [15:0] c16;
      logic [31:0] crc;
      for (int i = 0; i < 48; i++) exp_f[i] = HB[i];
      s = 0;
      for (int i = 22; i < 42; i += 2) s += {16'h0, exp_f[i], exp_f[i+1]};
      c16 = ~fold16(s);
      exp_f[32] = c16[15:8];
      exp_f[33] = c16[7:0];
      c16 = ~fold16(udp_partial(PLEN));
      if (c16 == 16'h0) c16 = 16'hffff;
      exp_f[48] = c16[15:8];
      exp_f[49] = c16[7:0];
      for (int i = 0; i < PLEN; i++) exp_f[50+i] = pay[i];
      crc = 32'hffffffff;
      for (int i = 8; i < 68; i++) begin
         crc = crc ^ {24'h0, exp_f[i]};
         for (int b = 0; b < 8; b++) crc = crc[0] ? ((crc >> 1) ^ 32'hedb88320) : (crc >> 1);
      end
      crc = ~crc;
      exp_f[68] = crc[7:0];
      exp_f[69] = crc[15:8];
      exp_f[70] = crc[23:16];
      exp_f[71] = crc[31:24];
   endtask

   function automatic string byte_req(input int i);
      if (i < 8) return "R3";
      if (i == 32 || i == 33) return "R5";
      if (i < 48) return "R4";
      if (i < 50) return "R6";
      if (i < 68) return "R7";
      return "R8";
   endfunction

   // send the payload, collect the frame, measure the gap
   task automatic run_frame(input bit junk);
      int n;
      bit vok;
      build_expected();
      for (int i = 0; i < PLEN; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = pay[i];
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = junk;
      in_data  = 8'hee;
      chk(!out_valid && !in_ready, "R9", "no output in cycle after last accept", {30'h0, out_valid, in_ready}, 32'h0);
      vok = 1'b1;
      for (int k = 0; k < FLEN; k++) begin
         @(negedge clk);
         if (!out_valid || in_ready) vok = 1'b0;
         got[k] = out_data;
      end
      in_valid = 1'b0;
      chk(vok, junk ? "R11" : "R9", "valid held and ready low for 72 cycles", {31'h0, vok}, 32'h1);
      for (int k = 0; k < FLEN; k++)
         chk(got[k] === exp_f[k], byte_req(k), $sformatf("frame byte %0d", k), {24'h0, got[k]}, {24'h0, exp_f[k]});
      n = 0;
      vok = 1'b1;
      for (int g = 0; g < 100; g++) begin
         @(negedge clk);
         if (in_ready) break;
         if (out_valid) vok = 1'b0;
         n++;
      end
      chk(n == IFG - 1 && vok, "R10", "idle cycles before ready", n, IFG - 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [15:0] w;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_valid && in_ready, "R1", "reset state", {30'h0, out_valid, in_ready}, 32'h1);

      // table of payload vectors
      for (int v = 0; v < 4; v++) begin
         for (int i = 0; i < PLEN; i++) pay[i] = VEC[v][8*(PLEN-1-i) +: 8];
         run_frame(1'b0);
      end

      // payload crafted so the UDP sum folds to zero: field must read 0xFFFF
      for (int i = 0; i < 16; i++) pay[i] = 8'(8'h31 * i + 8'h07);
      pay[16] = 8'h00;
      pay[17] = 8'h00;
      build_expected();
      w = ~fold16(udp_partial(16));
      pay[16] = w[15:8];
      pay[17] = w[7:0];
      run_frame(1'b0);
      chk({got[48], got[49]} == 16'hffff, "R6", "zero checksum sent as ffff", {16'h0, got[48], got[49]}, 32'hffff);

      // input activity while busy must not disturb the frame in flight
      for (int i = 0; i < PLEN; i++) pay[i] = 8'(8'hc3 ^ i);
      run_frame(1'b1);

      // mid-load reset returns to the idle state
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'h42;
      repeat (5) @(negedge clk);
      in_valid = 1'b0;
      rst_n    = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_valid && in_ready, "R1", "state after mid-load reset", {30'h0, out_valid, in_ready}, 32'h1);
      for (int i = 0; i < PLEN; i++) pay[i] = 8'(i);
      run_frame(1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule